// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus master and a bus slave that run on independent clocks and move one word per transfer with a fully interlocked request/acknowledge exchange. A user asks the master for a read or a write on a simple command port. The master puts the target address, the transfer direction and, for a write, the data onto the shared lines. It then waits a settle interval, set at run time, so that the slave can decode the target, and only after that does it raise request. The slave answers on a register-file port. It writes the word into the file, or it fetches a word and drives it back. It then raises acknowledge. The master lowers request, the slave lowers acknowledge, and the master only finishes the transfer once it has seen acknowledge low again.

Request and acknowledge each pass through a two-flop synchronizer in the domain that receives them. The address, direction and data lines are bundled data: they are held steady for the whole exchange, so they need no synchronizer. A parameter selects a shared-line variant in which the address and the data use the same wires in two successive exchanges. A watchdog counter can be set to abandon a transfer whose acknowledge never arrives.

Top module: `hs4_link`

## Requirements
- R1: After reset, cmd_ready is 1 and bus_req, bus_ack, rsp_valid and err are all 0.
- R2: bus_req rises exactly settle_cycles+1 master clock cycles after the edge that accepts a command (cmd_valid and cmd_ready both 1). In the shared-line variant the same settle interval comes before every exchange.
- R3: A write (cmd_write=1) gives exactly one single-cycle rf_we pulse in the slave domain, carrying cmd_addr on rf_addr and cmd_wdata on rf_wdata. Acknowledge rises on the same edge as the pulse.
- R4: A read (cmd_write=0) ends with a single-cycle rsp_valid pulse. While rsp_valid is high, rsp_rdata holds the register-file word at cmd_addr.
- R5: Request rises only while the synchronized acknowledge is low. Request falls only after acknowledge has been seen high, or on a watchdog abort. Acknowledge rises only after request has been seen high, and falls only after request has been seen low. The address, direction and data lines stay steady while request is high.
- R6: cmd_ready stays 0 from the accepting edge until the master has seen acknowledge low after the last exchange of the transfer, so no new command is taken while acknowledge is high.
- R7: With MUXED=1, each transfer uses two exchanges on the shared lines: the first carries the address, the second carries the write data or returns the read data. bus_req therefore rises twice per transfer. With MUXED=0 it rises once.
- R8: With WDOG_CYCLES=W>0, if acknowledge has not been seen W master cycles after request rose, then err is set, request drops and the master goes back to idle. err stays 1 until the next command is accepted, and is cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master-domain reset, active low, asynchronous |
| clk_s | input | 1 | Slave clock |
| rst_s_n | input | 1 | Slave-domain reset, active low, asynchronous |
| settle_cycles | input | CNT_W | Decode interval before request, in master cycles |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | Master idle and acknowledge seen low |
| rsp_valid | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_rdata | output | DW | Read data of the last read |
| err | output | 1 | Watchdog abort flag |
| rf_we | output | 1 | Register-file write strobe (slave clock) |
| rf_addr | output | AW | Register-file address |
| rf_wdata | output | DW | Register-file write data |
| rf_rdata | input | DW | Register-file read data for rf_addr |
| bus_req | output | 1 | Request line, master side |
| bus_ack | output | 1 | Acknowledge line, slave side |

## Verification
The hardest case to reach is the watchdog abort, because a working slave always answers. The bench holds the slave domain in reset while the master domain runs, so acknowledge stays low. It then counts the master cycles from the rise of request to the rise of err. After that it releases the slave and checks that the next transfer clears err and completes normally. The interlock is watched all the time by monitors on both clocks, and the two clock periods are unrelated. The shared-line variant runs as a second instance, so that the two exchanges per transfer can be counted.

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int CNT_W       = 4,
  parameter int WDOG_CYCLES = 12,
  parameter bit MUXED       = 1'b0
) (
  input  logic             clk_m,
  input  logic             rst_m_n,
  input  logic             clk_s,
  input  logic             rst_s_n,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_wdata,
  output logic             cmd_ready,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             err,
  output logic             rf_we,
  output logic [AW-1:0]    rf_addr,
  output logic [DW-1:0]    rf_wdata,
  input  logic [DW-1:0]    rf_rdata,
  output logic             bus_req,
  output logic             bus_ack
);

  localparam int WD_W = $clog2(WDOG_CYCLES + 2);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'((WDOG_CYCLES > 0) ? WDOG_CYCLES - 1 : 0);

  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_WAIT, M_REL} mst_t;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HOLD} slv_t;

  mst_t             m_st;
  slv_t             s_st;
  logic [AW-1:0]    m_addr, s_addr;
  logic [DW-1:0]    m_dat, s_dat, s_wd;
  logic             m_wr, m_ph, s_ph, s_oe;
  logic [CNT_W-1:0] cnt;
  logic [WD_W-1:0]  wd;
  logic [1:0]       ack_sync, req_sync;
  logic             ack_m, req_s;
  logic [DW-1:0]    ad_lines, rd_in, d_in;
  logic [AW-1:0]    a_in;

  // shared lines: slave drives them only while it returns read data
  assign ad_lines = s_oe ? s_dat : (m_ph ? m_dat : DW'(m_addr));
  assign rd_in    = MUXED ? ad_lines : s_dat;
  assign d_in     = MUXED ? ad_lines : m_dat;
  assign a_in     = MUXED ? ad_lines[AW-1:0] : m_addr;

  assign ack_m     = ack_sync[1];
  assign req_s     = req_sync[1];
  assign cmd_ready = (m_st == M_IDLE) && !ack_m;
  assign rf_addr   = s_addr;
  assign rf_wdata  = s_wd;

  always_ff @(posedge clk_m or negedge rst_m_n)
    if (!rst_m_n) ack_sync <= '0;
    else          ack_sync <= {ack_sync[0], bus_ack};

  always_ff @(posedge clk_s or negedge rst_s_n)
    if (!rst_s_n) req_sync <= '0;
    else          req_sync <= {req_sync[0], bus_req};

  always_ff @(posedge clk_m or negedge rst_m_n) begin
    if (!rst_m_n) begin
      m_st <= M_IDLE; m_addr <= '0; m_dat <= '0; m_wr <= 1'b0; m_ph <= 1'b0;
      cnt <= '0; wd <= '0; bus_req <= 1'b0; err <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (m_st)
        M_IDLE:
          if (cmd_valid && cmd_ready) begin
            m_addr <= cmd_addr; m_dat <= cmd_wdata; m_wr <= cmd_write;
            m_ph <= 1'b0; cnt <= '0; err <= 1'b0; m_st <= M_SETTLE;
          end
        M_SETTLE:
          if (cnt == settle_cycles) begin
            bus_req <= 1'b1; wd <= '0; m_st <= M_WAIT;
          end else cnt <= cnt + 1'b1;
        M_WAIT:
          if (ack_m) begin
            bus_req <= 1'b0;
            if (!m_wr && (!MUXED || m_ph)) rsp_rdata <= rd_in;
            m_st <= M_REL;
          end else if (WDOG_CYCLES > 0 && wd == WD_LAST) begin
            bus_req <= 1'b0; err <= 1'b1; m_st <= M_IDLE;
          end else wd <= wd + 1'b1;
        M_REL:
          if (!ack_m) begin
            if (MUXED && !m_ph) begin
              m_ph <= 1'b1; cnt <= '0; m_st <= M_SETTLE;
            end else begin
              rsp_valid <= 1'b1; m_st <= M_IDLE;
            end
          end
        default: m_st <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s_st <= S_IDLE; s_addr <= '0; s_wd <= '0; s_dat <= '0;
      s_ph <= 1'b0; s_oe <= 1'b0; bus_ack <= 1'b0; rf_we <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      case (s_st)
        S_IDLE:
          if (req_s) begin
            if (MUXED && !s_ph) begin
              s_addr <= a_in; s_ph <= 1'b1; bus_ack <= 1'b1; s_st <= S_HOLD;
            end else if (m_wr) begin
              if (!MUXED) s_addr <= a_in;
              s_wd <= d_in; rf_we <= 1'b1; s_ph <= 1'b0;
              bus_ack <= 1'b1; s_st <= S_HOLD;
            end else begin
              if (!MUXED) s_addr <= a_in;
              s_st <= S_FETCH;
            end
          end
        S_FETCH: begin
          s_dat <= rf_rdata; s_oe <= 1'b1; s_ph <= 1'b0;
          bus_ack <= 1'b1; s_st <= S_HOLD;
        end
        S_HOLD:
          if (!req_s) begin
            bus_ack <= 1'b0; s_oe <= 1'b0; s_st <= S_IDLE;
          end
        default: s_st <= S_IDLE;
      endcase
    end
  end

  assert_req_rise_ack_low_R5: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $rose(bus_req) |-> !$past(ack_m));
  assert_req_fall_after_ack_R5: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $fell(bus_req) |-> ($past(ack_m) || err));
  assert_lines_steady_R5: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    ($past(bus_req) && bus_req) |-> ($stable(m_addr) && $stable(m_wr) && $stable(m_dat)));
  assert_no_accept_ack_high_R6: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    ($past(m_st) == M_IDLE && m_st == M_SETTLE) |-> !$past(ack_m));
  assert_ack_rise_after_req_R5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(bus_ack) |-> $past(req_s));
  assert_ack_fall_after_req_low_R5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $fell(bus_ack) |-> !$past(req_s));
  assert_we_with_ack_R3: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    rf_we |-> (bus_ack && !$past(bus_ack)));

endmodule

// File: tb/hs4_link_tb_top.sv
module hs4_link_tb_top;
  localparam int W = 12;

  logic clk_m = 1'b0, clk_s = 1'b0;
  logic rst_m_n = 1'b0, rst_s_n = 1'b0;
  logic [3:0] settle = 4'd2;
  always #10 clk_m = ~clk_m;
  always #7  clk_s = ~clk_s;

  logic a_v = 0, a_w = 0, b_v = 0, b_w = 0;
  logic [3:0] a_ad = 0, b_ad = 0;
  logic [15:0] a_wd = 0, b_wd = 0;
  logic a_rdy, a_rv, a_err, a_we, a_req, a_ack;
  logic b_rdy, b_rv, b_err, b_we, b_req, b_ack;
  logic [15:0] a_rd, b_rd, a_rfw, b_rfw;
  logic [3:0] a_rfa, b_rfa;
  logic [15:0] rf_a [16];
  logic [15:0] rf_b [16];

  hs4_link #(.WDOG_CYCLES(W), .MUXED(1'b0)) dut_i (
    .clk_m, .rst_m_n, .clk_s, .rst_s_n, .settle_cycles(settle),
    .cmd_valid(a_v), .cmd_write(a_w), .cmd_addr(a_ad), .cmd_wdata(a_wd),
    .cmd_ready(a_rdy), .rsp_valid(a_rv), .rsp_rdata(a_rd), .err(a_err),
    .rf_we(a_we), .rf_addr(a_rfa), .rf_wdata(a_rfw), .rf_rdata(rf_a[a_rfa]),
    .bus_req(a_req), .bus_ack(a_ack));

  hs4_link #(.WDOG_CYCLES(W), .MUXED(1'b1)) dut_mx_i (
    .clk_m, .rst_m_n, .clk_s, .rst_s_n, .settle_cycles(settle),
    .cmd_valid(b_v), .cmd_write(b_w), .cmd_addr(b_ad), .cmd_wdata(b_wd),
    .cmd_ready(b_rdy), .rsp_valid(b_rv), .rsp_rdata(b_rd), .err(b_err),
    .rf_we(b_we), .rf_addr(b_rfa), .rf_wdata(b_rfw), .rf_rdata(rf_b[b_rfa]),
    .bus_req(b_req), .bus_ack(b_ack));

  int n_chk = 0, n_fail = 0;
  int a_wes = 0, b_wes = 0, a_rises = 0, b_rises = 0, viol5 = 0, viol6 = 0;
  logic a_req_q = 0, b_req_q = 0, a_ack_q = 0, b_ack_q = 0;

  initial for (int i = 0; i < 16; i++) begin rf_a[i] = 16'h0; rf_b[i] = 16'h0; end

  always @(posedge clk_s) begin
    if (a_we) begin rf_a[a_rfa] <= a_rfw; a_wes <= a_wes + 1; end
    if (b_we) begin rf_b[b_rfa] <= b_rfw; b_wes <= b_wes + 1; end
  end

  // interlock monitors away from the active edges
  always @(negedge clk_m) begin
    if (a_req && !a_req_q) a_rises <= a_rises + 1;
    if (b_req && !b_req_q) b_rises <= b_rises + 1;
    if (a_req_q && !a_req && !a_ack && !a_err) viol5 <= viol5 + 1;
    if (b_req_q && !b_req && !b_ack && !b_err) viol5 <= viol5 + 1;
    if ((a_rdy && a_ack) || (b_rdy && b_ack)) viol6 <= viol6 + 1;
    a_req_q <= a_req; b_req_q <= b_req;
  end
  always @(negedge clk_s) begin
    if (a_ack_q && !a_ack && a_req) viol5 <= viol5 + 1;
    if (b_ack_q && !b_ack && b_req) viol5 <= viol5 + 1;
    if (!a_ack_q && a_ack && !a_req) viol5 <= viol5 + 1;
    if (!b_ack_q && b_ack && !b_req) viol5 <= viol5 + 1;
    a_ack_q <= a_ack; b_ack_q <= b_ack;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit mx, input bit wr, input logic [3:0] ad, input logic [15:0] wd,
                     output int lat, output logic [15:0] rd, output int rises);
    int r0;
    int guard = 0;
    while (!(mx ? b_rdy : a_rdy) && guard < 500) begin @(negedge clk_m); guard++; end
    r0 = mx ? b_rises : a_rises;
    if (mx) begin b_v = 1; b_w = wr; b_ad = ad; b_wd = wd; end
    else    begin a_v = 1; a_w = wr; a_ad = ad; a_wd = wd; end
    @(negedge clk_m);
    a_v = 0; b_v = 0;
    check(!(mx ? b_rdy : a_rdy), "R6 ready low after accept", 1, 0);
    lat = 0;
    while (!(mx ? b_req : a_req) && lat < 100) begin @(negedge clk_m); lat++; end
    guard = 0;
    while (!(mx ? b_rv : a_rv) && guard < 500) begin @(negedge clk_m); guard++; end
    rd = mx ? b_rd : a_rd;
    check(guard < 500, "R4 rsp_valid seen", guard, 0);
    @(negedge clk_m);
    check(!(mx ? b_rv : a_rv), "R4 rsp_valid single cycle", 1, 0);
    rises = (mx ? b_rises : a_rises) - r0;
  endtask

  task automatic t_reset();
    check(a_rdy == 1 && b_rdy == 1, "R1 cmd_ready", {a_rdy, b_rdy}, 2'b11);
    check(!a_req && !a_ack && !b_req && !b_ack, "R1 req/ack idle", {a_req, a_ack, b_req, b_ack}, 0);
    check(!a_err && !a_rv && !b_err && !b_rv, "R1 err/rsp idle", {a_err, a_rv, b_err, b_rv}, 0);
  endtask

  task automatic t_write(input logic [3:0] ad, input logic [15:0] d, input logic [3:0] st);
    int lat, rs, w0;
    logic [15:0] rd;
    settle = st;
    w0 = a_wes;
    txn(0, 1, ad, d, lat, rd, rs);
    check(lat == st + 1, "R2 settle before req", lat, st + 1);
    check(a_wes - w0 == 1, "R3 one rf_we pulse", a_wes - w0, 1);
    check(rf_a[ad] == d, "R3 word written", rf_a[ad], d);
    check(rs == 1, "R7 single exchange when not shared", rs, 1);
  endtask

  task automatic t_read(input logic [3:0] ad, input logic [15:0] exp);
    int lat, rs;
    logic [15:0] rd;
    txn(0, 0, ad, 16'h0, lat, rd, rs);
    check(rd == exp, "R4 read data", rd, exp);
  endtask

  task automatic t_mux(input logic [3:0] ad, input logic [15:0] d);
    int lat, rs, w0;
    logic [15:0] rd;
    settle = 4'd3;
    w0 = b_wes;
    txn(1, 1, ad, d, lat, rd, rs);
    check(rs == 2, "R7 two exchanges on write", rs, 2);
    check(lat == 4, "R2 settle before address phase", lat, 4);
    check(b_wes - w0 == 1 && rf_b[ad] == d, "R7 shared-line write", rf_b[ad], d);
    txn(1, 0, ad, 16'h0, lat, rd, rs);
    check(rs == 2, "R7 two exchanges on read", rs, 2);
    check(rd == d, "R7 shared-line read", rd, d);
  endtask

  task automatic t_wdog();
    int n = 0, lat, rs;
    logic [15:0] rd;
    settle = 4'd1;
    rst_s_n = 0;
    while (!a_rdy) @(negedge clk_m);
    a_v = 1; a_w = 1; a_ad = 4'd9; a_wd = 16'hDEAD;
    @(negedge clk_m);
    a_v = 0;
    while (!a_req && n < 100) begin @(negedge clk_m); n++; end
    n = 0;
    while (!a_err && n < 100) begin @(negedge clk_m); n++; end
    check(n == W, "R8 watchdog delay", n, W);
    check(!a_req, "R8 request dropped", a_req, 0);
    check(a_rdy, "R8 back to idle", a_rdy, 1);
    repeat (3) @(negedge clk_m);
    check(a_err, "R8 err held", a_err, 1);
    rst_s_n = 1;
    repeat (4) @(negedge clk_m);
    txn(0, 1, 4'd9, 16'h1234, lat, rd, rs);
    check(!a_err, "R8 err cleared by next command", a_err, 0);
    check(rf_a[9] == 16'h1234, "R8 transfer after abort", rf_a[9], 16'h1234);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_m);
    rst_m_n = 1; rst_s_n = 1;
    repeat (2) @(negedge clk_m);
    t_reset();
    t_write(4'd3, 16'hA5C3, 4'd2);
    t_write(4'd0, 16'h0001, 4'd0);
    t_write(4'd15, 16'hFFFE, 4'd7);
    t_read(4'd3, 16'hA5C3);
    t_read(4'd15, 16'hFFFE);
    t_read(4'd7, 16'h0000);
    t_mux(4'd6, 16'h5A17);
    t_wdog();
    check(viol5 == 0, "R5 interlock order", viol5, 0);
    check(viol6 == 0, "R6 ready while ack high", viol6, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule